// File: doc/BRIEF.md
# Cascaded Register Shift Chain

This block joins a selectable number of 16-bit words, from one to thirty-two, into a single shift path of up to 512 bits. It is driven by three rung conditions: an enable, a shift command and a serial data bit. A direction input chooses whether bits move toward higher or lower positions. Each rising edge of the shift command moves every bit of the selected chain by one place. The serial data condition supplies the bit that enters, and the coil output takes the bit that falls out of the far end.

The words are held inside the block. Each one can be written through a parallel load port and read through a combinational read port. A four-bit request sets how many shifts may run in one enabled session. A running count tracks the shifts done, and a done flag stops further shifting once the request is met. Dropping the enable clears the whole chain, the count and the coil.

Top module: `shift_chain`

## Requirements
- R1: `len_i` holds the number of chained words minus one, so values 0 to 31 select 1 to 32 words. Words with an index above `len_i` keep their contents across a shift. Bits carry between adjacent words only inside the selected length.
- R2: With `dir_left_i` = 1, a shift moves every bit of the chain one place up. The entry bit goes into bit 0 of word 0. Bit 15 of word k moves into bit 0 of word k+1. The exit bit is bit 15 of word `len_i`. Example: words 0..2 holding FFFF, 0F0F, F0F0 with entry bit 0 become FFFE, 1E1F, E1E0, and the coil turns on.
- R3: With `dir_left_i` = 0, a shift moves every bit one place down. The entry bit goes into bit 15 of word `len_i`. Bit 0 of word k+1 moves into bit 15 of word k. The exit bit is bit 0 of word 0.
- R4: The entry bit equals `sdata_i` in the cycle in which the shift edge is seen.
- R5: `coil_o` holds the exit bit of the most recent shift, starting the cycle after that shift. It does not change in any cycle in which no shift happens.
- R6: While `en_i` is 0, one clock edge later all words read zero, `coil_o` is 0 and `cnt_o` is 0. A load presented while `en_i` is 0 is discarded.
- R7: Exactly one shift happens per rising edge of `shift_i`, sampled on `clk_i`. Holding `shift_i` high for several cycles gives a single shift.
- R8: `cnt_o` rises by one for each shift. `done_o` is 1 whenever `cnt_o` >= `nshift_i`. While `done_o` is 1, shift edges are ignored.
- R9: With `ld_i` = 1 and `en_i` = 1, word `ld_addr_i` takes `ld_data_i` at the next edge, whatever `len_i` is. If a shift edge arrives in the same cycle, the load wins and that shift edge is dropped and not counted.
- R10: `rd_data_o` shows word `rd_addr_i` combinationally.
- R11: After reset all words are zero, `coil_o` is 0 and `cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable rung condition; low clears the chain |
| shift_i | input | 1 | Shift command; each rising edge requests one shift |
| sdata_i | input | 1 | Serial data condition, the entry bit |
| dir_left_i | input | 1 | 1 shifts toward higher bits, 0 toward lower bits |
| len_i | input | 5 | Number of chained words minus one |
| nshift_i | input | 4 | Number of shifts allowed per session |
| ld_i | input | 1 | Parallel load strobe |
| ld_addr_i | input | 5 | Word index for the load |
| ld_data_i | input | 16 | Load data |
| rd_addr_i | input | 5 | Word index for the read port |
| rd_data_o | output | 16 | Contents of the addressed word |
| coil_o | output | 1 | Exit bit of the latest shift |
| cnt_o | output | 4 | Running shift count |
| done_o | output | 1 | Shift count has reached the request |

## Verification
The bench targets the word boundaries. A design that drops or misroutes the carry between words would corrupt the example pattern, and one that ignores the length would change or feed words above the chain. It also checks the exit bit at both ends for each direction, since a wrong exit pick would leave the coil tracking the wrong bit. Two cases check that a held shift command and a load in the same cycle as a shift edge each give no extra shift or count; a level-sensitive or priority-swapped design would move data twice or lose the load. A final case caps the count at a small request to confirm that a design which keeps shifting past done is caught by the words it changes.

// File: rtl/shift_chain_pkg.sv
package shift_chain_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/shift_chain_ctrl.sv
module shift_chain_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             shift_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] nshift_i,
  output logic             step_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= 1'b0;
    else         shift_q <= shift_i;
  end

  assign rise   = shift_i & ~shift_q;
  assign done_o = (cnt_q >= nshift_i);
  // load has priority; a colliding edge is dropped
  assign step_o = en_i & rise & ~ld_i & ~done_o;

  // count cannot wrap: at all-ones it is always done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (step_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/shift_chain_word.sv
module shift_chain_word
  import shift_chain_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic              step_i,
  input  shift_dir_e        dir_i,
  input  logic              lo_in_i,
  input  logic              hi_in_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (clr_i)  q <= '0;
    else if (ld_i)   q <= ld_data_i;
    else if (step_i) begin
      if (dir_i == DIR_UP) q <= {q[WORD_W-2:0], lo_in_i};
      else                 q <= {hi_in_i, q[WORD_W-1:1]};
    end
  end

  assign q_o = q;
endmodule

// File: rtl/shift_chain.sv
module shift_chain
  import shift_chain_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned N_WORDS = 32,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SEL_W   = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              shift_i,
  input  logic              sdata_i,
  input  logic              dir_left_i,
  input  logic [SEL_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  nshift_i,
  input  logic              ld_i,
  input  logic [SEL_W-1:0]  ld_addr_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic [SEL_W-1:0]  rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              coil_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);
  localparam int unsigned MSB = WORD_W - 1;

  shift_dir_e        dir;
  logic              step;
  logic              exit_bit;
  logic              coil_q;
  logic [WORD_W-1:0] q [N_WORDS];

  assign dir = dir_left_i ? DIR_UP : DIR_DOWN;

  shift_chain_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .shift_i  (shift_i),
    .ld_i     (ld_i),
    .nshift_i (nshift_i),
    .step_o   (step),
    .cnt_o    (cnt_o),
    .done_o   (done_o)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic in_chain;
    logic lo_in;
    logic hi_in;

    assign in_chain = (SEL_W'(k) <= len_i);

    if (k == 0) begin : g_lo_first
      assign lo_in = sdata_i;
    end else begin : g_lo_next
      assign lo_in = q[k-1][MSB];
    end

    if (k == N_WORDS - 1) begin : g_hi_last
      assign hi_in = sdata_i;
    end else begin : g_hi_next
      // top of the selected chain takes the serial bit
      assign hi_in = (SEL_W'(k) == len_i) ? sdata_i : q[k+1][0];
    end

    shift_chain_word #(.WORD_W(WORD_W)) u_word (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (~en_i),
      .ld_i      (ld_i && (ld_addr_i == SEL_W'(k))),
      .ld_data_i (ld_data_i),
      .step_i    (step && in_chain),
      .dir_i     (dir),
      .lo_in_i   (lo_in),
      .hi_in_i   (hi_in),
      .q_o       (q[k])
    );
  end

  assign exit_bit = (dir == DIR_UP) ? q[len_i][MSB] : q[0][0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    coil_q <= 1'b0;
    else if (!en_i) coil_q <= 1'b0;
    else if (step)  coil_q <= exit_bit;
  end

  assign coil_o    = coil_q;
  assign rd_data_o = q[rd_addr_i];
endmodule

// File: rtl/shift_chain_chk.sv
module shift_chain_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             shift_i,
  input logic             ld_i,
  input logic             coil_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             done_o
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (coil_o == 1'b0 && cnt_o == '0)); // R6

  AST_DONE_FREEZES_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_o) |=> $stable(cnt_o)); // R8

  AST_CNT_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1))); // R8

  AST_COIL_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !shift_i) |=> $stable(coil_o)); // R5

  AST_LOAD_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_i) |=> $stable(cnt_o)); // R9
endmodule

bind shift_chain shift_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .shift_i (shift_i),
  .ld_i    (ld_i),
  .coil_o  (coil_o),
  .cnt_o   (cnt_o),
  .done_o  (done_o)
);

// File: tb/shift_chain_bench.sv
`timescale 1ns/1ps
module shift_chain_bench;
  localparam int W  = 16;
  localparam int N  = 32;
  localparam int SW = 5;
  localparam int CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b1;
  logic          shift_i = 1'b0;
  logic          sdata_i = 1'b0;
  logic          dir_left_i = 1'b1;
  logic [SW-1:0] len_i = '0;
  logic [CW-1:0] nshift_i = 4'd15;
  logic          ld_i = 1'b0;
  logic [SW-1:0] ld_addr_i = '0;
  logic [W-1:0]  ld_data_i = '0;
  logic [SW-1:0] rd_addr_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          coil_o;
  logic [CW-1:0] cnt_o;
  logic          done_o;

  logic [W-1:0] exp_w [N];
  logic         exp_coil;
  int           exp_cnt;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           finished = 0;

  always #5 clk_i = ~clk_i;

  shift_chain u_shift_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .shift_i(shift_i),
    .sdata_i(sdata_i), .dir_left_i(dir_left_i), .len_i(len_i),
    .nshift_i(nshift_i), .ld_i(ld_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .coil_o(coil_o), .cnt_o(cnt_o), .done_o(done_o)
  );

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic check_state(string req);
    for (int k = 0; k < N; k++) begin
      rd_addr_i = SW'(k);
      #0.1;
      chk(req, $sformatf("word %0d", k), int'(rd_data_o), int'(exp_w[k]));
    end
    chk(req, "coil", int'(coil_o), int'(exp_coil));
    chk(req, "count", int'(cnt_o), exp_cnt);
    chk(req, "done", int'(done_o), int'(exp_cnt >= int'(nshift_i)));
  endtask

  function automatic void model_clear();
    for (int k = 0; k < N; k++) exp_w[k] = '0;
    exp_coil = 1'b0;
    exp_cnt  = 0;
  endfunction

  function automatic void model_step(bit left, bit sd, int len);
    logic [W-1:0] t [N];
    logic cin;
    if (!en_i || exp_cnt >= int'(nshift_i)) return;
    for (int k = 0; k < N; k++) t[k] = exp_w[k];
    for (int k = 0; k <= len; k++) begin
      if (left) begin
        cin = (k == 0) ? sd : t[k-1][W-1];
        exp_w[k] = {t[k][W-2:0], cin};
      end else begin
        cin = (k == len) ? sd : t[k+1][0];
        exp_w[k] = {cin, t[k][W-1:1]};
      end
    end
    exp_coil = left ? t[len][W-1] : t[0][0];
    exp_cnt++;
  endfunction

  task automatic do_load(int a, logic [W-1:0] d);
    @(negedge clk_i);
    ld_i = 1'b1; ld_addr_i = SW'(a); ld_data_i = d;
    if (en_i) exp_w[a] = d;
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic do_shift(bit left, bit sd);
    @(negedge clk_i);
    dir_left_i = left; sdata_i = sd; shift_i = 1'b1;
    model_step(left, sd, int'(len_i));
    @(negedge clk_i);
    shift_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_disable(bit with_load);
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    if (with_load) begin
      ld_i = 1'b1; ld_addr_i = '0; ld_data_i = 16'hBEEF;
    end
    @(negedge clk_i);
    ld_i = 1'b0;
    model_clear();
  endtask

  task automatic do_enable();
    @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'h5EED_1234));
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_state("R11");

    // example pattern, three words, word 3 must stay put
    len_i = 5'd2;
    do_load(0, 16'hFFFF);
    do_load(1, 16'h0F0F);
    do_load(2, 16'hF0F0);
    do_load(3, 16'h1234);
    do_load(31, 16'hA5A5);
    check_state("R9");
    do_shift(1'b1, 1'b0);
    check_state("R2");
    chk("R2", "example word1", int'(exp_w[1]), 32'h1E1F);
    chk("R5", "coil after left", int'(coil_o), 1);
    chk("R1", "word3 untouched", int'(exp_w[3]), 32'h1234);

    do_shift(1'b0, 1'b1);
    check_state("R3");
    do_shift(1'b1, 1'b1);
    check_state("R4");

    // held command: one shift only
    @(negedge clk_i);
    dir_left_i = 1'b0; sdata_i = 1'b0; shift_i = 1'b1;
    model_step(1'b0, 1'b0, int'(len_i));
    repeat (5) @(negedge clk_i);
    shift_i = 1'b0;
    @(negedge clk_i);
    check_state("R7");

    // load colliding with a shift edge
    @(negedge clk_i);
    ld_i = 1'b1; ld_addr_i = 5'd1; ld_data_i = 16'h8001;
    dir_left_i = 1'b1; shift_i = 1'b1; sdata_i = 1'b1;
    exp_w[1] = 16'h8001;
    @(negedge clk_i);
    ld_i = 1'b0; shift_i = 1'b0;
    @(negedge clk_i);
    check_state("R9");

    // disable clears, load ignored while disabled
    do_disable(1'b1);
    check_state("R6");
    do_enable();
    check_state("R6");

    // count cap
    nshift_i = 4'd2;
    len_i = 5'd0;
    do_load(0, 16'h0001);
    do_shift(1'b1, 1'b0);
    do_shift(1'b1, 1'b0);
    check_state("R8");
    do_shift(1'b1, 1'b1);
    check_state("R8");
    chk("R8", "word0 frozen", int'(exp_w[0]), 32'h0004);
    nshift_i = 4'd15;
    @(negedge clk_i);
    check_state("R8");

    // full length, exit from last word
    len_i = 5'd31;
    do_load(31, 16'h8000);
    do_load(0, 16'h0001);
    do_shift(1'b1, 1'b0);
    check_state("R1");
    do_shift(1'b0, 1'b0);
    check_state("R3");
    chk("R5", "coil right exit", int'(coil_o), 0);

    for (int i = 0; i < 300; i++) begin
      r = $urandom_range(0, 11);
      if (r <= 2) do_load($urandom_range(0, N-1), W'($urandom));
      else if (r <= 7) do_shift(1'($urandom), 1'($urandom));
      else if (r == 8) begin
        @(negedge clk_i); len_i = SW'($urandom_range(0, N-1));
      end else if (r == 9) begin
        @(negedge clk_i);
        nshift_i = ($urandom_range(0, 3) == 0) ? CW'($urandom_range(0, 15)) : 4'd15;
      end else begin
        do_disable(1'($urandom));
        do_enable();
      end
      @(negedge clk_i);
      check_state("R10");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule